// File: doc/BRIEF.md
# Hierarchical Priority Encoder Pixel Readout

This block drains a column of binary pixel hit latches, one pixel per clock. Each pixel holds a single-bit hit flag, which a hit strobe sets. A tree of identical four-input encoder nodes combines the flags into one "something pending" flag and one address. Each node resolves two address bits, so the address is assembled from the root down to the leaf. No clock reaches the tree.

A clocked controller sits at the top of the tree. In every cycle where the root reports a pending hit, the controller raises a select. That select runs back down the tree along the winning branch only. At the next clock edge it clears the one pixel whose address is being captured. The captured address and a valid flag form the readout stream.

The default tree has five levels, which gives 1024 leaf positions and a 10-bit address. Only the lower 512 positions carry real pixels. The upper positions stay permanently empty.

Top module: `pe_readout`

## Requirements
- R1: While rst_n is low, every hit latch is held clear and strobes are ignored. After reset, rd_valid is 0 and rd_addr is 0 until a strobe arrives.
- R2: A pixel whose hit_strobe bit is 1 at a rising clock edge has its latch set at that edge.
- R3: Latency: a latch set at edge N is reported at edge N+1. From edge N+1, rd_valid is 1 and rd_addr holds its address. It is never reported at edge N.
- R4: When several latches are set, the lowest pixel index is reported first. Every node prefers its lowest-numbered pending input, so the column drains in ascending index order.
- R5: rd_addr equals the pixel index, and bit pairs are ordered root first. Bits [9:8] come from the root node and bits [1:0] from the leaf node. Indices 0 and 511 are reported correctly, and bit 9 is never 1 with 512 pixels.
- R6: Each readout clears exactly the reported pixel. At most one latch is cleared per cycle, and a latch that is not set never receives a clear. A strobe on an already-set pixel that is not being read produces no second report.
- R7: After a clear at edge N, the next pending pixel is reported at edge N+1. K pending pixels are reported in K consecutive cycles with no gaps.
- R8: If a pixel's strobe coincides with the edge that clears it, the set wins. The latch stays set and the same address is reported again in the next cycle.
- R9: When no latch is set, no select is issued. At the following edge, rd_valid becomes 0 and rd_addr becomes 0.
- R10: A pixel strobed while a readout is in progress joins the pending set. It is reported in its index order relative to the pixels still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and latch clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_strobe | input | N_USED (512) | Per-pixel hit strobe; sets the latch at the clock edge |
| rd_valid | output | 1 | A pixel address was read out in this cycle |
| rd_addr | output | 2*LEVELS (10) | Index of the pixel read out; 0 when idle |

## Verification
Two events can land on the same pixel in the same cycle: the clear driven by the tree's select, and a fresh set from hit_strobe. The bench provokes this in two steps. It first strobes two pixels, then strobes the lower one again on exactly the edge where that pixel is read and cleared. The pass condition is that the lower address appears twice in back-to-back cycles before the higher one. A second coincidence is also tested: a strobe on a different pixel during a readout must merge into the ascending order without adding a gap or a duplicate.

// File: rtl/pe_readout_pkg.sv
// Package: shared constants and helpers for the priority encoder readout.
// Assumes a radix-4 tree; each level resolves LOC_W address bits.
package pe_readout_pkg;
    localparam int unsigned FANIN = 4;
    localparam int unsigned LOC_W = 2;

    // Number of nodes at tree level k (k = 0 is the leaf-facing level).
    function automatic int unsigned nodes_at(int unsigned leaves, int unsigned k);
        return leaves >> (LOC_W * (k + 1));
    endfunction
endpackage

// File: rtl/pe_node.sv
// Module: one 4-input encoder node. It is purely combinational.
// It forwards the OR of its valid inputs and the 2-bit index of the
// lowest pending input. It routes the incoming select only to that winner.
module pe_node
    import pe_readout_pkg::*;
(
    input  logic [FANIN-1:0] v_in,
    input  logic             sel_in,
    output logic             v_out,
    output logic [LOC_W-1:0] a_out,
    output logic [FANIN-1:0] sel_out
);
    logic [FANIN-1:0] win;

    // Lowest-index pending input wins; its one-hot mask gates the select.
    always_comb begin
        win   = '0;
        a_out = '0;
        if (v_in[0]) begin
            win[0] = 1'b1;
        end else if (v_in[1]) begin
            win[1] = 1'b1;
            a_out  = 2'd1;
        end else if (v_in[2]) begin
            win[2] = 1'b1;
            a_out  = 2'd2;
        end else if (v_in[3]) begin
            win[3] = 1'b1;
            a_out  = 2'd3;
        end
        v_out   = |v_in;
        sel_out = win & {FANIN{sel_in}};
    end
endmodule

// File: rtl/pe_tree.sv
// Module: radix-4 encoder tree of LEVELS levels over 4**LEVELS leaves.
// Valid and address travel upward and select travels downward. Every path
// is combinational. Address bit pairs are ordered root-first.
module pe_tree
    import pe_readout_pkg::*;
#(
    parameter int unsigned LEVELS = 5,
    localparam int unsigned N_LEAF = 1 << (LOC_W * LEVELS),
    localparam int unsigned ADDR_W = LOC_W * LEVELS
) (
    input  logic [N_LEAF-1:0] leaf_vld,
    input  logic              root_sel,
    output logic              root_vld,
    output logic [ADDR_W-1:0] root_addr,
    output logic [N_LEAF-1:0] leaf_sel
);
    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam int unsigned NN = nodes_at(N_LEAF, k);
        logic [FANIN*NN-1:0]        cv;   // child valids
        logic [FANIN*NN*ADDR_W-1:0] ca;   // child partial addresses
        logic [FANIN*NN-1:0]        cs;   // child selects
        logic [NN-1:0]              pv;   // node valids
        logic [NN*ADDR_W-1:0]       pa;   // node partial addresses
        logic [NN-1:0]              ps;   // node selects from above

        if (k == 0) begin : g_leaf
            assign cv       = leaf_vld;
            assign ca       = '0;
            assign leaf_sel = cs;
        end else begin : g_inner
            assign cv           = g_lvl[k-1].pv;
            assign ca           = g_lvl[k-1].pa;
            assign g_lvl[k-1].ps = cs;
        end

        for (genvar j = 0; j < NN; j++) begin : g_node
            logic [LOC_W-1:0]  a;
            logic [ADDR_W-1:0] sub;

            pe_node u_node (
                .v_in    (cv[FANIN*j +: FANIN]),
                .sel_in  (ps[j]),
                .v_out   (pv[j]),
                .a_out   (a),
                .sel_out (cs[FANIN*j +: FANIN])
            );

            // Pick the winning child's lower address bits and prepend this level's pair.
            assign sub = ca[(FANIN*j + int'(a))*ADDR_W +: ADDR_W];
            assign pa[j*ADDR_W +: ADDR_W] = sub | (ADDR_W'(a) << (LOC_W*k));
        end
    end

    assign g_lvl[LEVELS-1].ps = root_sel;
    assign root_vld  = g_lvl[LEVELS-1].pv[0];
    assign root_addr = g_lvl[LEVELS-1].pa[ADDR_W-1:0];
endmodule

// File: rtl/pe_pixels.sv
// Module: pixel hit latches, one set/clear flop per leaf position.
// Assumes the strobe and clear arrive synchronous to clk. A set wins over
// a clear on the same edge. Reset is synchronous and active low.
module pe_pixels #(
    parameter int unsigned N_LEAF = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_LEAF-1:0] hit,
    input  logic [N_LEAF-1:0] clr,
    output logic [N_LEAF-1:0] state
);
    // Hold, set on strobe, clear on select; the set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= '0;
        else        state <= hit | (state & ~clr);
    end
endmodule

// File: rtl/pe_periph.sv
// Module: clocked periphery controller at the tree root. It asserts the
// select combinationally whenever the root reports a pending hit. At the
// edge it registers the address and valid flag as the readout output.
module pe_periph #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              root_vld,
    input  logic [ADDR_W-1:0] root_addr,
    output logic              root_sel,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr
);
    assign root_sel = root_vld;

    // Capture the winning address each cycle; output zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_addr  <= '0;
        end else begin
            rd_valid <= root_vld;
            rd_addr  <= root_vld ? root_addr : '0;
        end
    end
endmodule

// File: rtl/pe_readout.sv
// Module: top of the hierarchical priority encoder readout. It holds the
// pixel latches, the combinational encoder tree and the clocked periphery.
// Pixels above N_USED are tied empty. Assumes N_USED <= 4**LEVELS.
module pe_readout
    import pe_readout_pkg::*;
#(
    parameter int unsigned LEVELS = 5,
    parameter int unsigned N_USED = 512
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_USED-1:0]         hit_strobe,
    output logic                      rd_valid,
    output logic [LOC_W*LEVELS-1:0]   rd_addr
);
    localparam int unsigned N_LEAF = 1 << (LOC_W * LEVELS);
    localparam int unsigned ADDR_W = LOC_W * LEVELS;

    logic [N_LEAF-1:0] hit_ext;
    logic [N_LEAF-1:0] pix_state;
    logic [N_LEAF-1:0] pix_clr;
    logic              root_vld;
    logic              root_sel;
    logic [ADDR_W-1:0] root_addr;

    assign hit_ext = N_LEAF'(hit_strobe);

    pe_pixels #(.N_LEAF(N_LEAF)) u_pix (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_ext),
        .clr   (pix_clr),
        .state (pix_state)
    );

    pe_tree #(.LEVELS(LEVELS)) u_tree (
        .leaf_vld  (pix_state),
        .root_sel  (root_sel),
        .root_vld  (root_vld),
        .root_addr (root_addr),
        .leaf_sel  (pix_clr)
    );

    pe_periph #(.ADDR_W(ADDR_W)) u_per (
        .clk       (clk),
        .rst_n     (rst_n),
        .root_vld  (root_vld),
        .root_addr (root_addr),
        .root_sel  (root_sel),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr)
    );
endmodule

// File: rtl/pe_readout_chk.sv
// Module: assertion checker for pe_readout, attached by bind. It watches the
// latch state, the clears from the tree and the readout outputs.
module pe_readout_chk #(
    parameter int unsigned N_LEAF = 1024,
    parameter int unsigned N_USED = 512,
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_LEAF-1:0] hit_ext,
    input logic [N_LEAF-1:0] pix_state,
    input logic [N_LEAF-1:0] pix_clr,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr
);
    assert_clr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pix_clr));

    assert_clr_only_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_clr & ~pix_state) == '0);

    assert_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pix_clr & ~hit_ext)) |=> ((pix_state & $past(pix_clr & ~hit_ext)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_ext) |=> (($past(hit_ext) & ~pix_state) == '0));

    assert_next_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pix_clr) |=> rd_valid);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pix_state) |=> (!rd_valid && rd_addr == '0));

    assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (int'(rd_addr) < N_USED));
endmodule

bind pe_readout pe_readout_chk #(
    .N_LEAF (N_LEAF),
    .N_USED (N_USED),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_ext   (hit_ext),
    .pix_state (pix_state),
    .pix_clr   (pix_clr),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr)
);

// File: tb/pe_readout_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver pushes expected addresses into a queue, and
// a monitor pops and compares each reported address.
module pe_readout_tb;
    localparam int N_USED = 512;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_USED-1:0] hit_strobe = '0;
    logic              rd_valid;
    logic [ADDR_W-1:0] rd_addr;

    int tests = 0;
    int fails = 0;
    int exp_q[$];

    pe_readout #(.LEVELS(5), .N_USED(N_USED)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_strobe (hit_strobe),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: every valid readout must match the queue head (R4 order, R5 value).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected readout", int'(rd_addr), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(rd_addr) == e, "R4/R5 readout address", int'(rd_addr), e);
            end
        end
    end

    task automatic push_mask(input logic [N_USED-1:0] m);
        for (int i = 0; i < N_USED; i++) if (m[i]) exp_q.push_back(i);
    endtask

    // Driver: m1 is applied at one edge and m2 at the next. The caller has
    // already pushed n_exp expected addresses.
    task automatic run(input logic [N_USED-1:0] m1, input logic [N_USED-1:0] m2,
                       input int n_exp);
        @(negedge clk); hit_strobe = m1;
        @(negedge clk); hit_strobe = m2;
        check(rd_valid == 1'b0, "R3 no report in set cycle", int'(rd_valid), 0);
        @(negedge clk); hit_strobe = '0;
        for (int j = 0; j < n_exp; j++) begin
            check(rd_valid == 1'b1, "R7 gapless readout", int'(rd_valid), 1);
            @(negedge clk);
        end
        check(rd_valid == 1'b0 && rd_addr == '0, "R9 idle after drain",
              int'(rd_addr), 0);
        check(exp_q.size() == 0, "R7 all expected reported", exp_q.size(), 0);
    endtask

    initial begin
        #800000;
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [N_USED-1:0] m;
        logic [N_USED-1:0] m2;
        // R1: strobes during reset are ignored
        hit_strobe = '1;
        repeat (3) @(negedge clk);
        hit_strobe = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R1 valid after reset", int'(rd_valid), 0);
        @(negedge clk);
        check(rd_valid == 1'b0 && rd_addr == '0, "R1 idle after reset", int'(rd_addr), 0);

        // R2 R5: lowest boundary pixel
        m = '0; m[0] = 1'b1; push_mask(m); run(m, '0, 1);
        // R5: highest boundary pixel
        m = '0; m[511] = 1'b1; push_mask(m); run(m, '0, 1);
        // R4: all four inputs of one leaf node
        m = '0; m[3:0] = 4'hF; push_mask(m); run(m, '0, 4);
        // R4 R5: hits spread across tree branches
        m = '0; m[511] = 1'b1; m[256] = 1'b1; m[255] = 1'b1;
        m[64] = 1'b1; m[17] = 1'b1; m[1] = 1'b1;
        push_mask(m); run(m, '0, 6);

        // R10: a new hit mid-readout merges in index order
        m = '0; m[100] = 1'b1; m[3] = 1'b1;
        m2 = '0; m2[50] = 1'b1;
        exp_q.push_back(3); exp_q.push_back(50); exp_q.push_back(100);
        run(m, m2, 3);

        // R8: strobe coincides with the clear of pixel 5, so it is read twice
        m = '0; m[5] = 1'b1; m[9] = 1'b1;
        m2 = '0; m2[5] = 1'b1;
        exp_q.push_back(5); exp_q.push_back(5); exp_q.push_back(9);
        run(m, m2, 3);

        // R6: re-strobing a set pixel that is not being read adds no report
        m = '0; m[30] = 1'b1; m[40] = 1'b1;
        m2 = '0; m2[40] = 1'b1;
        exp_q.push_back(30); exp_q.push_back(40);
        run(m, m2, 2);

        // R7: every eighth pixel, long gapless drain
        m = '0;
        for (int i = 0; i < N_USED; i += 8) m[i] = 1'b1;
        push_mask(m); run(m, '0, N_USED / 8);

        // R7 R4: full column
        m = '1; push_mask(m); run(m, '0, N_USED);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule